// File: doc/BRIEF.md
# Sub-word Read-Modify-Write Data Memory

This block is a small data memory organised as 64-bit rows that serves byte, halfword, word and doubleword loads and stores at arbitrary byte addresses. The low address bits select a byte position inside a row and the remaining bits select the row. A narrow load pulls the addressed lane out of the row and returns it zero-extended. A narrow store reads the current row, clears the addressed lane, inserts the new bytes and writes the merged row back in the same clock edge.

Each request may ask for the bytes of its lane to be reversed. This lets a core run either byte order over one storage layout. An access whose byte offset is not a multiple of its width is refused with a one-cycle error response. It is never split into several accesses. The response comes one clock after the request.

Top module: `subword_mem`

## Requirements
- R1: The byte address splits into a row index, which is the address shifted right by 3, and a byte offset, which is the address AND 7. Byte offset k of a row sits at bits [8k+7:8k] of the 64-bit row and of the doubleword read data.
- R2: An access whose offset AND (width-1) is nonzero is refused. The response shows rspErr=1 for exactly that one response cycle and rspRdata=0, and the stored contents do not change.
- R3: An aligned narrow read returns the addressed lane in the low bits of rspRdata. All higher bits are zero.
- R4: An aligned doubleword read returns the whole row.
- R5: An aligned narrow write replaces only the addressed bytes of the row. Every other byte of the row keeps its value.
- R6: An aligned doubleword write replaces the whole row.
- R7: After reset, every row that has not been written since reads as zero, and so does every byte that has not been written since.
- R8: With reqSwap=1, a read returns the extracted lane with its bytes reversed over exactly the access width.
- R9: With reqSwap=1, a write reverses the low access-width bytes of reqWdata before they are merged into the row.
- R10: reqSize encodes the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes.
- R11: A request with reqValid=1 gives rspValid=1 on the next cycle, and a cycle without a request gives rspValid=0. rspRdata is zero after writes, after refused accesses and after idle cycles. A read sees every write that committed on an earlier clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqAddr | input | 9 | Byte address |
| reqSize | input | 2 | Access width code |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqSwap | input | 1 | Reverse the bytes of the data lane |
| reqWdata | input | 64 | Store data, right-justified |
| rspValid | output | 1 | Response for the previous cycle's request |
| rspErr | output | 1 | The previous request was misaligned |
| rspRdata | output | 64 | Load data, zero-extended |

## Verification
The hardest case to reach combines a byte-reversed narrow store at a nonzero offset with a later load of a different width that overlaps it only partly. A wrong shift, a mask of the wrong width or a swap over the wrong width each shows up only in that mix. To reach it, the stimulus confines random traffic to a handful of rows, so every width, offset and swap setting keeps landing on bytes that earlier stores of other shapes left behind. A byte-array reference model predicts every response. Misaligned requests are mixed into the same traffic and then read back, which shows that a refused store leaves its row untouched.

// File: rtl/subword_mem_pkg.sv
package subword_mem_pkg;
  localparam int DATA_W    = 64;
  localparam int ROW_BYTES = DATA_W / 8;
  localparam int OFF_W     = $clog2(ROW_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } accSize_e;

  typedef struct packed {
    logic             doRead;
    logic             doWrite;
    logic             flagErr;
    logic [OFF_W-1:0] laneOff;
    accSize_e         size;
  } ctrlStrobe_t;

  function automatic int laneBytes(input accSize_e sz);
    return 1 << sz;
  endfunction

  function automatic logic [DATA_W-1:0] laneMask(input accSize_e sz);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < ROW_BYTES; i++)
      if (i < laneBytes(sz)) m[i*8 +: 8] = 8'hff;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] byteSwap(input logic [DATA_W-1:0] d,
                                                 input accSize_e sz);
    logic [DATA_W-1:0] r;
    int n;
    r = '0;
    n = laneBytes(sz);
    for (int i = 0; i < ROW_BYTES; i++)
      if (i < n) r[i*8 +: 8] = d[(n-1-i)*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/subword_ctrl.sv
module subword_ctrl
  import subword_mem_pkg::*;
#(
  parameter int ROWS   = 64,
  parameter int ADDR_W = $clog2(ROWS) + OFF_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [1:0]              reqSize,
  input  logic                    reqWrite,
  output logic [$clog2(ROWS)-1:0] rowIdx,
  output ctrlStrobe_t             strobe
);
  localparam int ROW_W = $clog2(ROWS);

  accSize_e         sizeCode;
  logic [OFF_W-1:0] byteOff;
  logic [OFF_W-1:0] alignBits;
  logic             aligned;

  always_comb begin
    sizeCode  = accSize_e'(reqSize);
    byteOff   = reqAddr[OFF_W-1:0];
    rowIdx    = reqAddr[OFF_W +: ROW_W];
    alignBits = OFF_W'(laneBytes(sizeCode) - 1);
    aligned   = (byteOff & alignBits) == '0;

    strobe.laneOff = byteOff;
    strobe.size    = sizeCode;
    strobe.doRead  = reqValid && aligned && !reqWrite;
    strobe.doWrite = reqValid && aligned && reqWrite;
    strobe.flagErr = reqValid && !aligned;
  end

  // R2: an odd address with any width above one byte must be refused
  p_odd_refused_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr[0] && reqSize != 2'd0) |-> (strobe.flagErr && !strobe.doWrite));

  // R2: a byte access is never refused
  p_byte_always_ok_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd0) |-> !strobe.flagErr);
endmodule

// File: rtl/subword_dp.sv
module subword_dp
  import subword_mem_pkg::*;
#(
  parameter int ROWS = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqSwap,
  input  logic [DATA_W-1:0]       reqWdata,
  input  logic [$clog2(ROWS)-1:0] rowIdx,
  input  ctrlStrobe_t             strobe,
  output logic                    rspValid,
  output logic                    rspErr,
  output logic [DATA_W-1:0]       rspRdata
);
  localparam int SHIFT_W = OFF_W + 3;

  logic [DATA_W-1:0] rowMem [ROWS];
  logic [ROWS-1:0]   rowLive;

  logic [DATA_W-1:0]  curRow;
  logic [SHIFT_W-1:0] shiftBits;
  logic [DATA_W-1:0]  lMask;
  logic [DATA_W-1:0]  readLane;
  logic [DATA_W-1:0]  readData;
  logic [DATA_W-1:0]  wrLane;
  logic [DATA_W-1:0]  mergedRow;

  always_comb begin
    curRow    = rowLive[rowIdx] ? rowMem[rowIdx] : '0;
    shiftBits = {strobe.laneOff, 3'b000};
    lMask     = laneMask(strobe.size);
    readLane  = (curRow >> shiftBits) & lMask;
    readData  = reqSwap ? byteSwap(readLane, strobe.size) : readLane;
    wrLane    = (reqSwap ? byteSwap(reqWdata, strobe.size) : reqWdata) & lMask;
    mergedRow = (curRow & ~(lMask << shiftBits)) | (wrLane << shiftBits);
  end

  always_ff @(posedge clk) begin
    if (strobe.doWrite) rowMem[rowIdx] <= mergedRow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowLive  <= '0;
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= '0;
    end else begin
      if (strobe.doWrite) rowLive[rowIdx] <= 1'b1;
      rspValid <= reqValid;
      rspErr   <= strobe.flagErr;
      rspRdata <= strobe.doRead ? readData : '0;
    end
  end

  // R2: a refused access returns no data
  p_err_zero_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspRdata == '0);

  // R2: a refused access leaves the addressed row and the written-row flags alone
  p_err_keeps_row_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flagErr |=> ($stable(rowLive) && rowMem[$past(rowIdx)] == $past(rowMem[rowIdx])));

  // R3: a byte read never returns data above the low byte
  p_byte_read_narrow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doRead && strobe.size == SZ_BYTE) |=> rspRdata[DATA_W-1:8] == '0);

  // R11: one response per request, on the following cycle
  p_resp_next_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_no_resp_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && rspRdata == '0));

  // R11: a store returns zero data
  p_write_zero_data_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doWrite |=> rspRdata == '0);
endmodule

// File: rtl/subword_mem.sv
module subword_mem
  import subword_mem_pkg::*;
#(
  parameter  int ROWS   = 64,
  localparam int ADDR_W = $clog2(ROWS) + subword_mem_pkg::OFF_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [1:0]          reqSize,
  input  logic                reqWrite,
  input  logic                reqSwap,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                rspValid,
  output logic                rspErr,
  output logic [DATA_W-1:0]   rspRdata
);
  logic [$clog2(ROWS)-1:0] rowIdx;
  ctrlStrobe_t             strobe;

  subword_ctrl #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .reqWrite (reqWrite),
    .rowIdx   (rowIdx),
    .strobe   (strobe)
  );

  subword_dp #(.ROWS(ROWS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqSwap  (reqSwap),
    .reqWdata (reqWdata),
    .rowIdx   (rowIdx),
    .strobe   (strobe),
    .rspValid (rspValid),
    .rspErr   (rspErr),
    .rspRdata (rspRdata)
  );
endmodule

// File: tb/subword_mem_tb.sv
module subword_mem_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [8:0]  reqAddr;
  logic [1:0]  reqSize;
  logic        reqWrite;
  logic        reqSwap;
  logic [63:0] reqWdata;
  logic        rspValid;
  logic        rspErr;
  logic [63:0] rspRdata;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] refMem [512];

  always #5 clk = ~clk;

  subword_mem u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqSwap(reqSwap),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspErr(rspErr),
    .rspRdata(rspRdata)
  );

  task automatic compare(input string tag, input logic ev, input logic ee,
                         input logic [63:0] ed);
    compared++;
    if (rspValid !== ev || rspErr !== ee || rspRdata !== ed) begin
      mismatched++;
      $display("FAIL %s: got valid=%0b err=%0b data=%h, expected valid=%0b err=%0b data=%h",
               tag, rspValid, rspErr, rspRdata, ev, ee, ed);
    end
  endtask

  // Behavioural reference: byte array, little-endian lanes, reversal on request.
  task automatic doOp(input string tag, input bit wr, input logic [8:0] a,
                      input logic [1:0] sz, input bit sw, input logic [63:0] wd);
    int n;
    logic [63:0] expData;
    logic expErr;
    n = 1 << sz;
    expData = '0;
    expErr = (int'(a) % n) != 0;
    if (!expErr) begin
      for (int i = 0; i < n; i++) begin
        int pos;
        pos = sw ? (n - 1 - i) : i;
        if (wr) refMem[int'(a) + i] = wd[pos*8 +: 8];
        else    expData[pos*8 +: 8] = refMem[int'(a) + i];
      end
      if (wr) expData = '0;
    end
    reqValid = 1'b1; reqAddr = a; reqSize = sz; reqWrite = wr;
    reqSwap = sw; reqWdata = wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    compare(tag, 1'b1, expErr, expData);
  endtask

  task automatic idleCheck(input string tag);
    reqValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    compare(tag, 1'b0, 1'b0, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL R11 watchdog: got no completion, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) refMem[i] = 8'h00;
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqSize = '0;
    reqWrite = 1'b0; reqSwap = 1'b0; reqWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    compare("R7 R11 reset state", 1'b0, 1'b0, 64'h0);

    doOp("R7 unwritten row", 0, 9'h028, 2'd3, 0, '0);
    doOp("R7 unwritten byte", 0, 9'h1ff, 2'd0, 0, '0);
    doOp("R6 full write", 1, 9'h010, 2'd3, 0, 64'h8877665544332211);
    doOp("R4 full read", 0, 9'h010, 2'd3, 0, '0);
    doOp("R1 R3 byte at offset 3", 0, 9'h013, 2'd0, 0, '0);
    doOp("R3 half at offset 6", 0, 9'h016, 2'd1, 0, '0);
    doOp("R8 swapped word read", 0, 9'h014, 2'd2, 1, '0);
    doOp("R8 swapped dword read", 0, 9'h010, 2'd3, 1, '0);
    doOp("R5 byte write", 1, 9'h011, 2'd0, 0, 64'hffffffffffffffab);
    doOp("R5 merged row", 0, 9'h010, 2'd3, 0, '0);
    doOp("R9 swapped half write", 1, 9'h01a, 2'd1, 1, 64'h1234);
    doOp("R9 merged row", 0, 9'h018, 2'd3, 0, '0);
    doOp("R2 misaligned half", 1, 9'h011, 2'd1, 0, 64'hdead);
    doOp("R2 misaligned word", 1, 9'h012, 2'd2, 0, 64'hdeadbeef);
    doOp("R2 misaligned dword read", 0, 9'h014, 2'd3, 0, '0);
    doOp("R2 row unchanged", 0, 9'h010, 2'd3, 0, '0);
    idleCheck("R11 idle");
    for (int s = 0; s < 4; s++) begin
      doOp("R10 size write", 1, 9'h040, 2'(s), 0, 64'h0102030405060708 + 64'(s));
      doOp("R10 size readback", 0, 9'h040, 2'd3, 0, '0);
    end
    doOp("R5 byte top of row", 1, 9'h047, 2'd0, 0, 64'h5a);
    doOp("R1 top byte placement", 0, 9'h040, 2'd3, 0, '0);

    for (int k = 0; k < 600; k++) begin
      bit wr, sw;
      logic [1:0] sz;
      logic [8:0] a;
      logic [63:0] wd;
      string tag;
      wr = ($urandom % 2) == 1;
      sw = ($urandom % 3) == 0;
      sz = 2'($urandom % 4);
      a  = ($urandom % 8 == 0) ? 9'($urandom) : 9'($urandom % 32);
      if ($urandom % 4 != 0) a = a & ~9'((1 << sz) - 1);
      wd = {$urandom, $urandom};
      if ((int'(a) % (1 << sz)) != 0) tag = "R2 random misaligned";
      else if (wr) tag = sw ? "R9 random" : (sz == 2'd3 ? "R6 random" : "R5 random");
      else tag = sw ? "R8 random" : (sz == 2'd3 ? "R4 random" : "R3 random");
      doOp(tag, wr, a, sz, sw, wd);
      if ($urandom % 16 == 0) idleCheck("R11 random idle");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule